// File: doc/BRIEF.md
# Shared Level Interrupt Balance Counter

This block resolves one wire-shared, active-low level interrupt line that several devices drive indirectly by writing "raise" and "release" events. A bus decoder upstream turns each such write into a one-cycle strobe on `assert_evt_i` or `deassert_evt_i`. The block keeps an up/down balance of those strobes. It holds the line low while any device still has an outstanding request, so one device releasing the line cannot cancel a request that another device has pending.

The balance is held by a small state machine. The states are `ST_IDLE` (balance zero, line high), `ST_HELD` (balance between one and the maximum minus one, line low) and `ST_FULL` (balance at the maximum, line low). Its transitions are:
- raise: `ST_IDLE` to `ST_HELD` on an increment.
- fill: `ST_HELD` to `ST_FULL` on an increment from maximum minus one.
- drain: `ST_FULL` to `ST_HELD` on a decrement.
- clear: `ST_HELD` to `ST_IDLE` on a decrement from one.

All other events keep the current state. An increment in `ST_FULL` sets the sticky overflow flag, and a decrement in `ST_IDLE` sets the sticky underflow flag. One instance serves one line, so four instances cover four shared lines.

Top module: `shared_irq_balance`

## Requirements
- R1: A cycle with only `assert_evt_i` high adds one to the balance. From a zero balance, `irq_n_o` goes low in the cycle after the strobe.
- R2: A cycle with only `deassert_evt_i` high takes one from the balance. `irq_n_o` returns high only once the number of deassert strobes equals the number of assert strobes.
- R3: When one device asserts, a second device asserts, and the first then deasserts, `irq_n_o` stays low until the second device's deassert arrives.
- R4: When both strobes are high in the same cycle, the balance, the line and both flags are left as they were.
- R5: The balance is 3 bits wide by default and tracks up to seven outstanding requests. After seven asserts, seven deasserts are needed before the line goes high.
- R6: An assert when the balance is at its maximum (7) keeps the balance at 7 and sets `ovf_o`.
- R7: A deassert when the balance is 0 keeps the balance at 0 and sets `unf_o`.
- R8: `ovf_o` and `unf_o` stay set after they are set, whatever strobes follow, until reset.
- R9: Synchronous reset (`rst` high at a rising clock edge) clears the balance and both flags and leaves `irq_n_o` high.
- R10: `irq_n_o` is active low and comes from registered state. A strobe never changes it in the strobe's own cycle, only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| assert_evt_i | input | 1 | One-cycle strobe: a device raises its request |
| deassert_evt_i | input | 1 | One-cycle strobe: a device releases its request |
| irq_n_o | output | 1 | Resolved shared interrupt line, active low |
| ovf_o | output | 1 | Sticky flag: an assert arrived when the balance was full |
| unf_o | output | 1 | Sticky flag: a deassert arrived when the balance was zero |

## Verification
The balance is driven in several ways:
- A lone assert/deassert pair shows the one-cycle registered delay.
- An interleaved two-device sequence separates a true balance from a "last write wins" line.
- Coincident strobes show whether they cancel or one of them wins.
- A climb to seven and back shows that the line needs exactly as many releases as requests.

Pushing past the top and below the bottom tells saturation apart from wrap-around. After each of those, the count of strobes it takes to change the line shows where the balance actually settled, and the flags are checked to stay set after further traffic.

// File: rtl/shlvl_pkg.sv
package shlvl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HELD,
        ST_FULL
    } bal_state_e;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_UP,
        OP_DOWN
    } bal_op_e;

endpackage

// File: rtl/shlvl_evt_merge.sv
module shlvl_evt_merge
    import shlvl_pkg::*;
(
    input  logic    up_i,
    input  logic    dn_i,
    output bal_op_e op_o
);

    // Coincident strobes cancel each other out.
    always_comb begin
        unique case ({up_i, dn_i})
            2'b10:   op_o = OP_UP;
            2'b01:   op_o = OP_DOWN;
            default: op_o = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/shlvl_balance_fsm.sv
module shlvl_balance_fsm
    import shlvl_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  bal_op_e          op_i,
    output bal_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_up_o,
    output logic             sat_dn_o
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_MAX - 1'b1;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    bal_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State and balance register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state and next-balance logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_i == OP_UP) begin
                    state_d = ST_HELD;            // raise
                    cnt_d   = CNT_ONE;
                end
            end
            ST_HELD: begin
                if (op_i == OP_UP) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_NEAR)
                        state_d = ST_FULL;        // fill
                end else if (op_i == OP_DOWN) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CNT_ONE)
                        state_d = ST_IDLE;        // clear
                end
            end
            ST_FULL: begin
                if (op_i == OP_DOWN) begin
                    state_d = ST_HELD;            // drain
                    cnt_d   = CNT_NEAR;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs: saturation requests and the registered state
    always_comb begin
        state_o  = state_q;
        cnt_o    = cnt_q;
        sat_up_o = (state_q == ST_FULL) && (op_i == OP_UP);
        sat_dn_o = (state_q == ST_IDLE) && (op_i == OP_DOWN);
    end

endmodule

// File: rtl/shlvl_sticky_flags.sv
module shlvl_sticky_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_FLAGS-1:0] set_i,
    output logic [N_FLAGS-1:0] flag_o
);

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst)
                flag_q <= 1'b0;
            else if (set_i[g])
                flag_q <= 1'b1;
        end
        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/shared_irq_balance.sv
module shared_irq_balance
    import shlvl_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic assert_evt_i,
    input  logic deassert_evt_i,
    output logic irq_n_o,
    output logic ovf_o,
    output logic unf_o
);

    bal_op_e          bal_op;
    bal_state_e       bal_state;
    logic [CNT_W-1:0] bal_cnt;
    logic             sat_up, sat_dn;
    logic [1:0]       flags;

    shlvl_evt_merge u_merge (
        .up_i (assert_evt_i),
        .dn_i (deassert_evt_i),
        .op_o (bal_op)
    );

    shlvl_balance_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .op_i     (bal_op),
        .state_o  (bal_state),
        .cnt_o    (bal_cnt),
        .sat_up_o (sat_up),
        .sat_dn_o (sat_dn)
    );

    shlvl_sticky_flags #(.N_FLAGS(2)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  ({sat_dn, sat_up}),
        .flag_o (flags)
    );

    always_comb begin
        irq_n_o = (bal_state == ST_IDLE);
        ovf_o   = flags[0];
        unf_o   = flags[1];
    end

endmodule

// File: rtl/shlvl_balance_chk.sv
module shlvl_balance_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             assert_evt_i,
    input logic             deassert_evt_i,
    input logic             irq_n_o,
    input logic             ovf_o,
    input logic             unf_o,
    input logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R1
    raise_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (assert_evt_i && !deassert_evt_i && irq_n_o) |=> !irq_n_o);

    // R2
    line_matches_balance_chk: assert property (@(posedge clk) disable iff (rst)
        irq_n_o == (cnt == '0));

    // R4
    coincident_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (assert_evt_i && deassert_evt_i) |=>
            ($stable(cnt) && $stable(irq_n_o) && $stable(ovf_o) && $stable(unf_o)));

    // R6
    overflow_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (assert_evt_i && !deassert_evt_i && cnt == CNT_MAX) |=> (ovf_o && cnt == CNT_MAX));

    // R7
    underflow_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (deassert_evt_i && !assert_evt_i && cnt == '0) |=> (unf_o && cnt == '0));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        unf_o |=> unf_o);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (irq_n_o && !ovf_o && !unf_o && cnt == '0));

endmodule

bind shared_irq_balance shlvl_balance_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .assert_evt_i   (assert_evt_i),
    .deassert_evt_i (deassert_evt_i),
    .irq_n_o        (irq_n_o),
    .ovf_o          (ovf_o),
    .unf_o          (unf_o),
    .cnt            (bal_cnt)
);

// File: tb/shared_irq_balance_test.sv
module shared_irq_balance_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_evt = 1'b0;
    logic d_evt = 1'b0;
    logic irq_n, ovf, unf;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    shared_irq_balance uut (
        .clk            (clk),
        .rst            (rst),
        .assert_evt_i   (a_evt),
        .deassert_evt_i (d_evt),
        .irq_n_o        (irq_n),
        .ovf_o          (ovf),
        .unf_o          (unf)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Drive one cycle of strobes; on return the registered result is visible.
    task automatic step(input logic a, input logic d);
        @(negedge clk);
        a_evt = a;
        d_evt = d;
        @(posedge clk);
        #1;
        a_evt = 1'b0;
        d_evt = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R9", "irq_n after reset", irq_n, 1'b1);
        check("R9", "ovf after reset", ovf, 1'b0);
        check("R9", "unf after reset", unf, 1'b0);
    endtask

    task automatic t_single();
        do_reset();
        @(negedge clk);
        a_evt = 1'b1;
        #1;
        check("R10", "irq_n in strobe cycle", irq_n, 1'b1);
        @(posedge clk);
        #1;
        a_evt = 1'b0;
        check("R1", "irq_n after one assert", irq_n, 1'b0);
        step(1'b0, 1'b1);
        check("R2", "irq_n after matching deassert", irq_n, 1'b1);
        check("R2", "no unf on balanced release", unf, 1'b0);
    endtask

    task automatic t_interleave();
        do_reset();
        step(1'b1, 1'b0);          // device A
        step(1'b1, 1'b0);          // device B
        step(1'b0, 1'b1);          // device A releases
        check("R3", "irq_n while B pending", irq_n, 1'b0);
        step(1'b0, 1'b1);          // device B releases
        check("R3", "irq_n after both released", irq_n, 1'b1);
    endtask

    task automatic t_simul();
        do_reset();
        step(1'b1, 1'b1);
        check("R4", "irq_n after both at zero", irq_n, 1'b1);
        check("R4", "unf after both at zero", unf, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check("R4", "irq_n after both at one", irq_n, 1'b0);
        step(1'b0, 1'b1);
        check("R4", "balance still one", irq_n, 1'b1);
    endtask

    task automatic t_depth();
        do_reset();
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        check("R5", "no ovf at seven", ovf, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
        check("R5", "irq_n after six releases", irq_n, 1'b0);
        step(1'b0, 1'b1);
        check("R5", "irq_n after seventh release", irq_n, 1'b1);
        check("R5", "no unf", unf, 1'b0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
        check("R6", "ovf after eighth assert", ovf, 1'b1);
        check("R6", "irq_n held low", irq_n, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
        check("R6", "balance saturated at 7 (low after 6)", irq_n, 1'b0);
        step(1'b0, 1'b1);
        check("R6", "balance saturated at 7 (high after 7)", irq_n, 1'b1);
        check("R8", "ovf still set", ovf, 1'b1);
        step(1'b1, 1'b1);
        check("R8", "ovf set after more traffic", ovf, 1'b1);
    endtask

    task automatic t_underflow();
        do_reset();
        step(1'b0, 1'b1);
        check("R7", "unf after release at zero", unf, 1'b1);
        check("R7", "irq_n high at zero", irq_n, 1'b1);
        step(1'b1, 1'b0);
        check("R7", "one assert drives low", irq_n, 1'b0);
        step(1'b0, 1'b1);
        check("R7", "balance held at zero (high again)", irq_n, 1'b1);
        check("R8", "unf still set", unf, 1'b1);
        check("R8", "ovf untouched", ovf, 1'b0);
    endtask

    task automatic t_reset_clears();
        step(1'b1, 1'b0);
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
        do_reset();
        check("R9", "irq_n after mid-run reset", irq_n, 1'b1);
        check("R9", "ovf cleared", ovf, 1'b0);
        check("R9", "unf cleared", unf, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check("R9", "balance restarted from zero", irq_n, 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_single();
        t_interleave();
        t_simul();
        t_depth();
        t_overflow();
        t_underflow();
        t_reset_clears();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R1-all: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule